// File: doc/BRIEF.md
# Fast Ethernet Transceiver Reset and Strap Sequencer

This block decides when the digital core of a 10/100 Ethernet transceiver comes out of reset, and which parts of that core are reset. Two events start a reset. The first is a hardware reset: the shared active-low reset line is held low, either by this block at power-up or by an external agent. The second is a software reset: the management side writes the reset-request bit of the control register.

Each event drives its own set of per-block reset outputs. While the line is low, the block also captures the speed and duplex strap pins into an auto-negotiation advertisement. During every reset it forces the activity, collision and link indicators on, and keeps them on for a stretch afterwards, so that a person can see a short reset.

The reset line is modelled as open drain. The block reads the line on `rstPinIn` and pulls it low with `rstPinDriveLow`; an external pull-up supplies the high level. Analog bring-up is summarised by the `xcvrReady` input. `powerOnRstN` is the power-on indication, and it also acts as the asynchronous reset of the block's own flops.

Top module: `phy_rst_top`

## Requirements
- R1: While `powerOnRstN` is low, and afterwards until `xcvrReady` is seen high, `rstPinDriveLow` is 1. In that state all four reset outputs are 1, all three LED outputs are 1, and `dataEnable` is 0.
- R2: `rstPinDriveLow` falls in the cycle after `xcvrReady` is sampled high and never rises again until the next power-on. If an external agent keeps the line low after that release, every reset output stays asserted.
- R3: The line passes through a two-flop synchroniser. A low level counts as a hardware reset only after it has been seen for MIN_PULSE_NS·CLK_MHZ/1000 cycles, rounded up (13 cycles at the defaults). A shorter low pulse leaves `rstCtl` at 0.
- R4: `dataEnable` is 1 only while the synchronised line reads high and `rstMgmt` is 0.
- R5: On every cycle the synchronised line reads low, and during power-up, `advSpeed100` takes the inverse of `spdStrap` (low strap advertises 100 Mb/s) and `advFullDpx` takes `dpxStrap` (high strap advertises full duplex). While the line reads high, changes on the strap pins have no effect on either output.
- R6: A write with `ctlWrEn`=1 and `ctlWrRstBit`=1 (bit 15 of control register 0) is a software reset. It asserts `rstMgmt`, `rstPcs` and `rstScr` from the next cycle, and it leaves `rstCtl` at 0. `ctlRstBit` reads 1 for the whole sequence and then clears by itself. A write with `ctlWrRstBit`=0 has no effect.
- R7: A qualified hardware reset asserts all four reset outputs, including `rstCtl`.
- R8: Each reset output stays asserted for exactly HOLD_CYCLES cycles after the event that triggered it ends.
- R9: Each LED output is the OR of its pass-through input and a force term. The force term is 1 while `rstMgmt` is 1, and for STRETCH_US·CLK_MHZ cycles after `rstMgmt` falls (at least 1 ms at the defaults).
- R10: A new reset that arrives during an LED stretch restarts the stretch, so the stretch is timed from the end of the latest reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| powerOnRstN | input | 1 | Power-on indication, active low; asynchronous reset of the block |
| rstPinIn | input | 1 | Level read back from the open-drain reset line |
| rstPinDriveLow | output | 1 | Pull the reset line low when 1 |
| xcvrReady | input | 1 | Analog transceiver initialisation complete |
| ctlWrEn | input | 1 | Write strobe for control register 0 |
| ctlWrRstBit | input | 1 | Value written to the reset-request bit (bit 15) |
| spdStrap | input | 1 | Speed strap pin; low means 100 Mb/s capable |
| dpxStrap | input | 1 | Duplex strap pin; high means full-duplex capable |
| actIn | input | 1 | Normal activity indication |
| colIn | input | 1 | Normal collision indication |
| linkIn | input | 1 | Normal link indication |
| advSpeed100 | output | 1 | Advertise 100 Mb/s |
| advFullDpx | output | 1 | Advertise full duplex |
| rstMgmt | output | 1 | Reset for the management registers |
| rstPcs | output | 1 | Reset for the PCS receive, transmit and auto-negotiation machines |
| rstScr | output | 1 | Reset for both scramblers |
| rstCtl | output | 1 | Reset for the device control state machine (hardware only) |
| ctlRstBit | output | 1 | Read value of the self-clearing reset bit |
| dataEnable | output | 1 | Transmit and receive may run |
| ledActOn | output | 1 | Activity LED drive |
| ledColOn | output | 1 | Collision LED drive |
| ledLinkOn | output | 1 | Link LED drive |

## Verification
The bench builds the block at the default 125 MHz with a 100 ns minimum pulse, so the qualification threshold is 13 cycles. It drives low pulses of exactly 12 cycles and exactly 13 cycles, which tests the boundary on both sides. STRETCH_US is lowered to 2, giving a 250-cycle LED stretch. That brings the end of a stretch, and a restart of it by a software reset partway through, within a short run. HOLD_CYCLES is 4, so every per-block hold tail is short enough to compare cycle by cycle against the reference model.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic hwTrig;      // hardware reset event in progress
    logic swTrig;      // one-cycle software reset request
    logic latchStraps; // capture strap pins this cycle
    logic lineHigh;    // synchronised reset line reads high
  } rstStrobe_t;
endpackage

// File: rtl/phy_rst_ctrl.sv
module phy_rst_ctrl
  import phy_rst_pkg::*;
#(
  parameter int CLK_MHZ      = 125,
  parameter int MIN_PULSE_NS = 100
) (
  input  logic       clk,
  input  logic       powerOnRstN,
  input  logic       rstPinIn,
  input  logic       xcvrReady,
  input  logic       ctlWrEn,
  input  logic       ctlWrRstBit,
  output logic       rstPinDriveLow,
  output rstStrobe_t strb
);
  localparam int MIN_CYC = (MIN_PULSE_NS * CLK_MHZ + 999) / 1000;
  localparam int LOW_W   = $clog2(MIN_CYC + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(MIN_CYC - 1);

  logic [1:0]       syncQ;
  logic [LOW_W-1:0] lowCnt;
  logic             porActive;
  logic             swPulse;

  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      syncQ     <= 2'b00;
      lowCnt    <= '0;
      porActive <= 1'b1;
      swPulse   <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rstPinIn};
      if (syncQ[1])              lowCnt <= '0;
      else if (lowCnt != LOW_LAST) lowCnt <= lowCnt + 1'b1;
      if (xcvrReady) porActive <= 1'b0;
      swPulse <= ctlWrEn & ctlWrRstBit;
    end
  end

  assign rstPinDriveLow   = porActive;
  assign strb.hwTrig      = porActive | (~syncQ[1] & (lowCnt == LOW_LAST));
  assign strb.swTrig      = swPulse;
  assign strb.latchStraps = porActive | ~syncQ[1];
  assign strb.lineHigh    = syncQ[1];
endmodule

// File: rtl/phy_rst_datapath.sv
module phy_rst_datapath
  import phy_rst_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int STRETCH_US  = 1000,
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       powerOnRstN,
  input  rstStrobe_t strb,
  input  logic       spdStrap,
  input  logic       dpxStrap,
  input  logic       actIn,
  input  logic       colIn,
  input  logic       linkIn,
  output logic       advSpeed100,
  output logic       advFullDpx,
  output logic       rstHw,
  output logic       rstAll,
  output logic       dataEnable,
  output logic [2:0] ledOn
);
  localparam int HOLD_W  = $clog2(HOLD_CYCLES + 1);
  localparam int LED_CYC = STRETCH_US * CLK_MHZ;
  localparam int LED_W   = $clog2(LED_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(HOLD_CYCLES);
  localparam logic [LED_W-1:0]  LED_LD  = LED_W'(LED_CYC);

  logic [1:0] trig;
  logic [1:0] held;
  assign trig[0] = strb.hwTrig;
  assign trig[1] = strb.hwTrig | strb.swTrig;

  for (genvar g = 0; g < 2; g++) begin : g_hold
    logic [HOLD_W-1:0] cnt;
    always_ff @(posedge clk or negedge powerOnRstN) begin
      if (!powerOnRstN)    cnt <= '0;
      else if (trig[g])    cnt <= HOLD_LD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
    assign held[g] = trig[g] | (cnt != '0);
  end

  assign rstHw  = held[0];
  assign rstAll = held[1];

  logic [LED_W-1:0] ledCnt;
  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN)       ledCnt <= '0;
    else if (rstAll)        ledCnt <= LED_LD;
    else if (ledCnt != '0)  ledCnt <= ledCnt - 1'b1;
  end

  logic ledForce;
  assign ledForce = rstAll | (ledCnt != '0);
  assign ledOn    = {linkIn, colIn, actIn} | {3{ledForce}};

  always_ff @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      advSpeed100 <= 1'b0;
      advFullDpx  <= 1'b0;
    end else if (strb.latchStraps) begin
      advSpeed100 <= ~spdStrap;
      advFullDpx  <= dpxStrap;
    end
  end

  assign dataEnable = strb.lineHigh & ~rstAll;
endmodule

// File: rtl/phy_rst_top.sv
module phy_rst_top
  import phy_rst_pkg::*;
#(
  parameter int CLK_MHZ      = 125,
  parameter int MIN_PULSE_NS = 100,
  parameter int STRETCH_US   = 1000,
  parameter int HOLD_CYCLES  = 4
) (
  input  logic clk,
  input  logic powerOnRstN,
  input  logic rstPinIn,
  output logic rstPinDriveLow,
  input  logic xcvrReady,
  input  logic ctlWrEn,
  input  logic ctlWrRstBit,
  input  logic spdStrap,
  input  logic dpxStrap,
  input  logic actIn,
  input  logic colIn,
  input  logic linkIn,
  output logic advSpeed100,
  output logic advFullDpx,
  output logic rstMgmt,
  output logic rstPcs,
  output logic rstScr,
  output logic rstCtl,
  output logic ctlRstBit,
  output logic dataEnable,
  output logic ledActOn,
  output logic ledColOn,
  output logic ledLinkOn
);
  rstStrobe_t strb;
  logic rstHw, rstAll;
  logic [2:0] ledOn;

  phy_rst_ctrl #(.CLK_MHZ(CLK_MHZ), .MIN_PULSE_NS(MIN_PULSE_NS)) u_ctrl (
    .clk(clk), .powerOnRstN(powerOnRstN), .rstPinIn(rstPinIn),
    .xcvrReady(xcvrReady), .ctlWrEn(ctlWrEn), .ctlWrRstBit(ctlWrRstBit),
    .rstPinDriveLow(rstPinDriveLow), .strb(strb)
  );

  phy_rst_datapath #(.CLK_MHZ(CLK_MHZ), .STRETCH_US(STRETCH_US),
                     .HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk(clk), .powerOnRstN(powerOnRstN), .strb(strb),
    .spdStrap(spdStrap), .dpxStrap(dpxStrap),
    .actIn(actIn), .colIn(colIn), .linkIn(linkIn),
    .advSpeed100(advSpeed100), .advFullDpx(advFullDpx),
    .rstHw(rstHw), .rstAll(rstAll), .dataEnable(dataEnable), .ledOn(ledOn)
  );

  assign rstMgmt   = rstAll;
  assign rstPcs    = rstAll;
  assign rstScr    = rstAll;
  assign rstCtl    = rstHw;
  assign ctlRstBit = rstAll;
  assign {ledLinkOn, ledColOn, ledActOn} = ledOn;
endmodule

// File: rtl/phy_rst_checker.sv
module phy_rst_checker (
  input logic clk,
  input logic powerOnRstN,
  input logic rstPinIn,
  input logic rstPinDriveLow,
  input logic xcvrReady,
  input logic advSpeed100,
  input logic advFullDpx,
  input logic rstMgmt,
  input logic rstCtl,
  input logic dataEnable,
  input logic ledActOn,
  input logic ledColOn,
  input logic ledLinkOn
);
  AST_POR_HOLDS: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (rstPinDriveLow && !xcvrReady) |=> rstPinDriveLow); // R1
  AST_NO_REDRIVE: assert property (@(posedge clk) disable iff (!powerOnRstN)
    !rstPinDriveLow |=> !rstPinDriveLow); // R2
  AST_DATA_GATED: assert property (@(posedge clk) disable iff (!powerOnRstN)
    dataEnable |-> (!rstMgmt && $past(rstPinIn, 2))); // R4
  AST_STRAP_STABLE: assert property (@(posedge clk) disable iff (!powerOnRstN)
    (!rstPinDriveLow && rstPinIn && $past(rstPinIn) && $past(rstPinIn, 2) && $past(rstPinIn, 3))
      |-> ($stable(advSpeed100) && $stable(advFullDpx))); // R5
  AST_CTL_IMPLIES_ALL: assert property (@(posedge clk) disable iff (!powerOnRstN)
    rstCtl |-> rstMgmt); // R7
  AST_LED_IN_RESET: assert property (@(posedge clk) disable iff (!powerOnRstN)
    rstMgmt |-> (ledActOn && ledColOn && ledLinkOn)); // R9
  AST_LED_AFTER_RESET: assert property (@(posedge clk) disable iff (!powerOnRstN)
    $fell(rstMgmt) |-> (ledActOn && ledColOn && ledLinkOn)); // R9
endmodule

bind phy_rst_top phy_rst_checker u_chk (
  .clk(clk), .powerOnRstN(powerOnRstN), .rstPinIn(rstPinIn),
  .rstPinDriveLow(rstPinDriveLow), .xcvrReady(xcvrReady),
  .advSpeed100(advSpeed100), .advFullDpx(advFullDpx),
  .rstMgmt(rstMgmt), .rstCtl(rstCtl), .dataEnable(dataEnable),
  .ledActOn(ledActOn), .ledColOn(ledColOn), .ledLinkOn(ledLinkOn)
);

// File: tb/phy_rst_top_tb.sv
`timescale 1ns/1ps
module phy_rst_top_tb;
  localparam int CLK_MHZ = 125;
  localparam int MINP    = 13;   // ceil(100 ns * 125 MHz)
  localparam int HOLD    = 4;
  localparam int STRETCH = 250;  // 2 us * 125 MHz

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic powerOnRstN = 1'b0, xcvrReady = 1'b0, extLow = 1'b0;
  logic ctlWrEn = 1'b0, ctlWrRstBit = 1'b0;
  logic spdStrap = 1'b0, dpxStrap = 1'b1;
  logic actIn = 1'b0, colIn = 1'b0, linkIn = 1'b0;
  logic rstPinDriveLow, advSpeed100, advFullDpx, rstMgmt, rstPcs, rstScr, rstCtl;
  logic ctlRstBit, dataEnable, ledActOn, ledColOn, ledLinkOn;
  wire  rstPinIn = !(extLow || rstPinDriveLow);

  phy_rst_top #(.CLK_MHZ(CLK_MHZ), .MIN_PULSE_NS(100), .STRETCH_US(2),
                .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .powerOnRstN(powerOnRstN), .rstPinIn(rstPinIn),
    .rstPinDriveLow(rstPinDriveLow), .xcvrReady(xcvrReady),
    .ctlWrEn(ctlWrEn), .ctlWrRstBit(ctlWrRstBit),
    .spdStrap(spdStrap), .dpxStrap(dpxStrap),
    .actIn(actIn), .colIn(colIn), .linkIn(linkIn),
    .advSpeed100(advSpeed100), .advFullDpx(advFullDpx),
    .rstMgmt(rstMgmt), .rstPcs(rstPcs), .rstScr(rstScr), .rstCtl(rstCtl),
    .ctlRstBit(ctlRstBit), .dataEnable(dataEnable),
    .ledActOn(ledActOn), .ledColOn(ledColOn), .ledLinkOn(ledLinkOn)
  );

  int checks = 0, errors = 0;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  // Behavioural reference: integers tracking line history and remaining times
  bit mPor, mS1, mS2, mSw, mAdv100, mAdvFd;
  int mLowRun, mHwLeft, mAllLeft, mLedLeft;

  function automatic bit mHwEvt();
    return mPor || (!mS2 && mLowRun >= MINP - 1);
  endfunction
  function automatic bit mRstHw();  return mHwEvt() || mHwLeft > 0; endfunction
  function automatic bit mRstAll(); return mHwEvt() || mSw || mAllLeft > 0; endfunction
  function automatic bit mForce();  return mRstAll() || mLedLeft > 0; endfunction

  always @(posedge clk or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      mPor = 1; mS1 = 0; mS2 = 0; mSw = 0; mAdv100 = 0; mAdvFd = 0;
      mLowRun = 0; mHwLeft = 0; mAllLeft = 0; mLedLeft = 0;
    end else begin
      bit hwE, allE, rAll, pinNow;
      hwE    = mHwEvt();
      allE   = hwE || mSw;
      rAll   = mRstAll();
      pinNow = !(extLow || mPor);
      if (!mS2 || mPor) begin mAdv100 = !spdStrap; mAdvFd = dpxStrap; end
      mHwLeft  = hwE  ? HOLD : (mHwLeft  > 0 ? mHwLeft  - 1 : 0);
      mAllLeft = allE ? HOLD : (mAllLeft > 0 ? mAllLeft - 1 : 0);
      mLedLeft = rAll ? STRETCH : (mLedLeft > 0 ? mLedLeft - 1 : 0);
      mLowRun  = mS2 ? 0 : (mLowRun < MINP - 1 ? mLowRun + 1 : mLowRun);
      if (xcvrReady) mPor = 0;
      mSw = ctlWrEn && ctlWrRstBit;
      mS2 = mS1; mS1 = pinNow;
    end
  end

  // Compare every cycle, half a period after the active edge
  always @(negedge clk) begin
    check("R2", "rstPinDriveLow", rstPinDriveLow, mPor);
    check("R5", "advSpeed100", advSpeed100, mAdv100);
    check("R5", "advFullDpx", advFullDpx, mAdvFd);
    check("R6", "rstMgmt", rstMgmt, mRstAll());
    check("R6", "rstPcs", rstPcs, mRstAll());
    check("R6", "rstScr", rstScr, mRstAll());
    check("R7", "rstCtl", rstCtl, mRstHw());
    check("R8", "ctlRstBit", ctlRstBit, mRstAll());
    check("R4", "dataEnable", dataEnable, mS2 && !mRstAll());
    check("R9", "ledActOn", ledActOn, actIn || mForce());
    check("R9", "ledColOn", ledColOn, colIn || mForce());
    check("R10", "ledLinkOn", ledLinkOn, linkIn || mForce());
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic swWrite(input logic bitVal);
    ctlWrEn = 1'b1; ctlWrRstBit = bitVal;
    step(1);
    ctlWrEn = 1'b0; ctlWrRstBit = 1'b0;
  endtask

  bit sawCtl, sawAll;

  initial begin
    step(5);
    @(negedge clk); #1;
    check("R1", "drive low in power-on", rstPinDriveLow, 1'b1);
    check("R1", "rstCtl in power-on", rstCtl, 1'b1);
    check("R1", "dataEnable in power-on", dataEnable, 1'b0);
    step(1);
    powerOnRstN = 1'b1;
    step(10);
    extLow = 1'b1;            // external agent extends the low period
    xcvrReady = 1'b1;
    step(20);
    @(negedge clk); #1;
    check("R2", "drive released", rstPinDriveLow, 1'b0);
    check("R2", "resets held by external low", rstCtl, 1'b1);
    extLow = 1'b0;
    step(STRETCH + 30);
    @(negedge clk); #1;
    check("R4", "data enabled when idle", dataEnable, 1'b1);
    check("R9", "LED stretch expired", ledActOn, 1'b0);

    // Software reset with bit clear: no effect
    swWrite(1'b0);
    step(3);
    @(negedge clk); #1;
    check("R6", "bit15=0 write ignored", rstMgmt, 1'b0);

    // Software reset
    sawCtl = 0; sawAll = 0;
    swWrite(1'b1);
    repeat (HOLD + 4) begin
      @(negedge clk); #1;
      if (rstCtl) sawCtl = 1;
      if (rstMgmt) sawAll = 1;
    end
    check("R6", "sw reset asserts rstMgmt", sawAll, 1'b1);
    check("R6", "sw reset spares rstCtl", sawCtl, 1'b0);
    check("R6", "self-clear", ctlRstBit, 1'b0);
    step(STRETCH + 10);

    // Short low pulse (MINP-1 cycles) with new straps
    spdStrap = 1'b1; dpxStrap = 1'b0;
    sawCtl = 0;
    extLow = 1'b1;
    repeat (MINP - 1) begin
      step(1);
      if (rstCtl) sawCtl = 1;
    end
    extLow = 1'b0;
    repeat (6) begin step(1); if (rstCtl) sawCtl = 1; end
    check("R3", "short pulse ignored", sawCtl, 1'b0);
    check("R5", "strap latched low speed", advSpeed100, 1'b0);
    check("R5", "strap latched half duplex", advFullDpx, 1'b0);

    // Exactly MINP cycles low: qualified hardware reset
    spdStrap = 1'b0; dpxStrap = 1'b1;
    sawCtl = 0;
    extLow = 1'b1;
    step(MINP);
    extLow = 1'b0;
    repeat (6) begin step(1); if (rstCtl) sawCtl = 1; end
    check("R7", "min pulse qualifies", sawCtl, 1'b1);
    check("R5", "strap 100M", advSpeed100, 1'b1);
    spdStrap = 1'b1; dpxStrap = 1'b0;   // ignored while line high
    step(40);
    check("R5", "strap ignored while high", advSpeed100, 1'b1);
    check("R8", "hold ended", rstMgmt, 1'b0);

    // Software reset mid-stretch restarts the stretch
    swWrite(1'b1);
    step(STRETCH - 10);
    check("R10", "stretch restarted", ledLinkOn, 1'b1);
    step(40);
    check("R9", "stretch ended", ledLinkOn, 1'b0);

    // Pass-through when not forced
    actIn = 1'b1; linkIn = 1'b1;
    step(3);
    check("R9", "act pass-through", ledActOn, 1'b1);
    check("R9", "col pass-through", ledColOn, 1'b0);
    step(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule